// File: doc/BRIEF.md
# DDS Parameter Source Priority Selector

This block sits in front of the phase accumulator and output stage of a direct digital synthesizer core. It decides where each of the three tuning words (frequency, phase offset, amplitude) comes from, every clock. There are five candidate sources:

- playback words from a waveform RAM
- a ramp generator
- a 16-bit parallel modulation port, combined with base and offset registers
- an output shift-keying amplitude
- the single-tone words of the currently selected profile

Each parameter has its own fixed priority list. The block also handles polar modulation: a single data word is split between phase and amplitude, and the low bits of each come from offset registers.

All selection logic is combinational and feeds one output register stage. Every selected word is paired with a 3-bit source code, so downstream logic and test equipment can see which input won. The block has no states. The output register is its only storage. It loads on every rising edge and clears to zero under the active-low reset.

Top module: `dds_src_sel`

## Requirements
- R1: While `rst_n` is low, every output word reads zero and every source code reads 0 (profile).
- R2: Outputs change only at a rising edge. They show the selection made from the inputs present just before that edge, so the latency is one cycle.
- R3: Frequency priority, highest first:
  - RAM enabled with RAM destination frequency;
  - ramp enabled with ramp destination frequency;
  - parallel enabled with parallel destination frequency;
  - `ctl_ftw` whenever RAM is enabled with any other destination;
  - otherwise `prof_ftw`.
  
  Destination codes for RAM and parallel are 0 frequency, 1 phase, 2 amplitude, 3 polar.
- R4: Phase priority, highest first:
  - RAM targeting phase or polar;
  - ramp targeting phase;
  - parallel targeting phase;
  - parallel targeting polar;
  - `ctl_pow` whenever RAM is enabled with a destination other than phase or polar;
  - otherwise `prof_pow`.
- R5: Amplitude priority, highest first:
  - shift-keying enabled (`osk_amp`);
  - RAM targeting amplitude or polar;
  - ramp targeting amplitude;
  - parallel targeting amplitude;
  - parallel targeting polar;
  - otherwise `prof_asf`.
- R6: The parallel frequency word is `par_base_ftw + (par_data << par_gain)`, modulo 2^32. The 4-bit `par_gain` is a shift amount, giving a gain from 1 to 32768.
- R7: Parallel polar mode builds two words:
  - phase: `{par_data[15:8], par_pow_lsb[7:0]}`;
  - amplitude: `{par_data[7:0], par_asf_lsb[5:0]}`.
  
  For direct parallel targets, phase is `par_data` and amplitude is `par_data[15:2]`.
- R8: RAM words are used as follows:
  - frequency: the whole 32-bit word;
  - phase: `ram_word[31:16]`;
  - amplitude: `ram_word[31:18]`;
  - polar: phase from `ram_word[31:16]` and amplitude from `ram_word[15:2]`.
- R9: Ramp destination codes are 0 frequency, 1 phase, 2 amplitude. Code 3 is ignored, so the ramp then drives no parameter. Ramp phase is `ramp_word[31:16]` and ramp amplitude is `ramp_word[31:18]`.
- R10: Source codes:

  | Code | Source |
  |---|---|
  | 0 | profile |
  | 1 | control register |
  | 2 | parallel |
  | 3 | parallel polar |
  | 4 | ramp |
  | 5 | RAM |
  | 6 | shift-keying |

  The frequency code never takes 3 or 6, the phase code never takes 6, and the amplitude code never takes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ram_en | input | 1 | RAM playback enable |
| ram_dest | input | 2 | RAM destination code |
| ram_word | input | 32 | Current RAM playback word |
| ramp_en | input | 1 | Ramp generator enable |
| ramp_dest | input | 2 | Ramp destination code |
| ramp_word | input | 32 | Ramp generator output |
| par_en | input | 1 | Parallel port enable |
| par_dest | input | 2 | Parallel destination code |
| par_gain | input | 4 | Frequency gain as a shift amount |
| par_data | input | 16 | Parallel modulation data |
| par_base_ftw | input | 32 | Base frequency word for parallel FM |
| par_pow_lsb | input | 8 | Phase low bits for polar mode |
| par_asf_lsb | input | 6 | Amplitude low bits for polar mode |
| osk_en | input | 1 | Shift-keying enable |
| osk_amp | input | 14 | Shift-keying amplitude |
| ctl_ftw | input | 32 | Frequency word used while RAM drives another parameter |
| ctl_pow | input | 16 | Phase word used while RAM drives another parameter |
| prof_ftw | input | 32 | Active profile frequency word |
| prof_pow | input | 16 | Active profile phase word |
| prof_asf | input | 14 | Active profile amplitude word |
| ftw_q | output | 32 | Selected frequency word |
| pow_q | output | 16 | Selected phase word |
| asf_q | output | 14 | Selected amplitude word |
| ftw_src | output | 3 | Frequency source code |
| pow_src | output | 3 | Phase source code |
| asf_src | output | 3 | Amplitude source code |

## Verification
Each priority list is tested by enabling several competing sources at once and then removing the winner one at a time. At each step the next source down the list must take over, and the word and source code must change together. Distinct bit patterns are used for every source value, so a wrong field slice or a swapped polar half shows up as a wrong value rather than a coincidental match. The parallel frequency path is tested with three cases:
- a sum that wraps past 2^32;
- the maximum shift;
- a mid-range shift.

The ignored ramp destination code is tested with no other source enabled, so the profile words must pass through unchanged.

// File: rtl/dds_sel_pkg.sv
package dds_sel_pkg;

    typedef enum logic [1:0] {
        DST_FREQ  = 2'd0,
        DST_PHASE = 2'd1,
        DST_AMP   = 2'd2,
        DST_POLAR = 2'd3
    } dest_e;

    typedef enum logic [2:0] {
        SRC_PROFILE   = 3'd0,
        SRC_REG       = 3'd1,
        SRC_PAR       = 3'd2,
        SRC_PAR_POLAR = 3'd3,
        SRC_RAMP      = 3'd4,
        SRC_RAM       = 3'd5,
        SRC_SHIFTKEY  = 3'd6
    } src_e;

endpackage

// File: rtl/dds_par_scale.sv
module dds_par_scale #(
    parameter int FTW_W  = 32,
    parameter int PAR_W  = 16,
    parameter int GAIN_W = 4
) (
    input  logic [PAR_W-1:0]  data,
    input  logic [GAIN_W-1:0] gain,
    input  logic [FTW_W-1:0]  base,
    output logic [FTW_W-1:0]  sum
);
    localparam int PAD_W = FTW_W - PAR_W;

    logic [FTW_W-1:0] wide;

    always_comb begin
        wide = {{PAD_W{1'b0}}, data} << gain;
        sum  = base + wide;
    end
endmodule

// File: rtl/dds_freq_sel.sv
module dds_freq_sel
    import dds_sel_pkg::*;
#(
    parameter int FTW_W = 32
) (
    input  logic             ram_en,
    input  dest_e            ram_dest,
    input  logic [FTW_W-1:0] ram_word,
    input  logic             ramp_en,
    input  logic [1:0]       ramp_dest,
    input  logic [FTW_W-1:0] ramp_word,
    input  logic             par_en,
    input  dest_e            par_dest,
    input  logic [FTW_W-1:0] par_ftw,
    input  logic [FTW_W-1:0] ctl_ftw,
    input  logic [FTW_W-1:0] prof_ftw,
    output logic [FTW_W-1:0] word,
    output src_e             src
);
    always_comb begin
        if (ram_en && ram_dest == DST_FREQ) begin
            word = ram_word;
            src  = SRC_RAM;
        end else if (ramp_en && ramp_dest == 2'd0) begin
            word = ramp_word;
            src  = SRC_RAMP;
        end else if (par_en && par_dest == DST_FREQ) begin
            word = par_ftw;
            src  = SRC_PAR;
        end else if (ram_en) begin
            word = ctl_ftw;
            src  = SRC_REG;
        end else begin
            word = prof_ftw;
            src  = SRC_PROFILE;
        end
    end
endmodule

// File: rtl/dds_pa_sel.sv
module dds_pa_sel
    import dds_sel_pkg::*;
#(
    parameter int FTW_W = 32,
    parameter int POW_W = 16,
    parameter int ASF_W = 14,
    parameter int PAR_W = 16
) (
    input  logic             ram_en,
    input  dest_e            ram_dest,
    input  logic [FTW_W-1:0] ram_word,
    input  logic             ramp_en,
    input  logic [1:0]       ramp_dest,
    input  logic [FTW_W-1:0] ramp_word,
    input  logic             par_en,
    input  dest_e            par_dest,
    input  logic [PAR_W-1:0] par_data,
    input  logic [POW_W-PAR_W/2-1:0] par_pow_lsb,
    input  logic [ASF_W-PAR_W/2-1:0] par_asf_lsb,
    input  logic             osk_en,
    input  logic [ASF_W-1:0] osk_amp,
    input  logic [POW_W-1:0] ctl_pow,
    input  logic [POW_W-1:0] prof_pow,
    input  logic [ASF_W-1:0] prof_asf,
    output logic [POW_W-1:0] pow_word,
    output src_e             pow_src,
    output logic [ASF_W-1:0] asf_word,
    output src_e             asf_src
);
    localparam int HALF_W = PAR_W / 2;

    logic ram_ph, ram_am, par_polar;

    always_comb begin
        ram_ph    = ram_en && (ram_dest == DST_PHASE || ram_dest == DST_POLAR);
        ram_am    = ram_en && (ram_dest == DST_AMP || ram_dest == DST_POLAR);
        par_polar = par_en && par_dest == DST_POLAR;
    end

    // Phase selection
    always_comb begin
        if (ram_ph) begin
            pow_word = ram_word[FTW_W-1 -: POW_W];
            pow_src  = SRC_RAM;
        end else if (ramp_en && ramp_dest == 2'd1) begin
            pow_word = ramp_word[FTW_W-1 -: POW_W];
            pow_src  = SRC_RAMP;
        end else if (par_en && par_dest == DST_PHASE) begin
            pow_word = par_data[PAR_W-1 -: POW_W];
            pow_src  = SRC_PAR;
        end else if (par_polar) begin
            pow_word = {par_data[PAR_W-1 -: HALF_W], par_pow_lsb};
            pow_src  = SRC_PAR_POLAR;
        end else if (ram_en) begin
            pow_word = ctl_pow;
            pow_src  = SRC_REG;
        end else begin
            pow_word = prof_pow;
            pow_src  = SRC_PROFILE;
        end
    end

    // Amplitude selection
    always_comb begin
        if (osk_en) begin
            asf_word = osk_amp;
            asf_src  = SRC_SHIFTKEY;
        end else if (ram_am) begin
            asf_word = (ram_dest == DST_POLAR) ? ram_word[POW_W-1 -: ASF_W]
                                               : ram_word[FTW_W-1 -: ASF_W];
            asf_src  = SRC_RAM;
        end else if (ramp_en && ramp_dest == 2'd2) begin
            asf_word = ramp_word[FTW_W-1 -: ASF_W];
            asf_src  = SRC_RAMP;
        end else if (par_en && par_dest == DST_AMP) begin
            asf_word = par_data[PAR_W-1 -: ASF_W];
            asf_src  = SRC_PAR;
        end else if (par_polar) begin
            asf_word = {par_data[HALF_W-1:0], par_asf_lsb};
            asf_src  = SRC_PAR_POLAR;
        end else begin
            asf_word = prof_asf;
            asf_src  = SRC_PROFILE;
        end
    end
endmodule

// File: rtl/dds_src_sel.sv
module dds_src_sel
    import dds_sel_pkg::*;
#(
    parameter int FTW_W  = 32,
    parameter int POW_W  = 16,
    parameter int ASF_W  = 14,
    parameter int PAR_W  = 16,
    parameter int GAIN_W = 4,
    localparam int PLSB_W = POW_W - PAR_W / 2,
    localparam int ALSB_W = ASF_W - PAR_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ram_en,
    input  logic [1:0]        ram_dest,
    input  logic [FTW_W-1:0]  ram_word,
    input  logic              ramp_en,
    input  logic [1:0]        ramp_dest,
    input  logic [FTW_W-1:0]  ramp_word,
    input  logic              par_en,
    input  logic [1:0]        par_dest,
    input  logic [GAIN_W-1:0] par_gain,
    input  logic [PAR_W-1:0]  par_data,
    input  logic [FTW_W-1:0]  par_base_ftw,
    input  logic [PLSB_W-1:0] par_pow_lsb,
    input  logic [ALSB_W-1:0] par_asf_lsb,
    input  logic              osk_en,
    input  logic [ASF_W-1:0]  osk_amp,
    input  logic [FTW_W-1:0]  ctl_ftw,
    input  logic [POW_W-1:0]  ctl_pow,
    input  logic [FTW_W-1:0]  prof_ftw,
    input  logic [POW_W-1:0]  prof_pow,
    input  logic [ASF_W-1:0]  prof_asf,
    output logic [FTW_W-1:0]  ftw_q,
    output logic [POW_W-1:0]  pow_q,
    output logic [ASF_W-1:0]  asf_q,
    output logic [2:0]        ftw_src,
    output logic [2:0]        pow_src,
    output logic [2:0]        asf_src
);
    dest_e            ram_d, par_d;
    logic [FTW_W-1:0] par_ftw, ftw_d;
    logic [POW_W-1:0] pow_d;
    logic [ASF_W-1:0] asf_d;
    src_e             ftw_s, pow_s, asf_s;
    src_e             ftw_sq, pow_sq, asf_sq;

    assign ram_d = dest_e'(ram_dest);
    assign par_d = dest_e'(par_dest);

    dds_par_scale #(.FTW_W(FTW_W), .PAR_W(PAR_W), .GAIN_W(GAIN_W)) u_scale (
        .data(par_data), .gain(par_gain), .base(par_base_ftw), .sum(par_ftw)
    );

    dds_freq_sel #(.FTW_W(FTW_W)) u_freq (
        .ram_en(ram_en), .ram_dest(ram_d), .ram_word(ram_word),
        .ramp_en(ramp_en), .ramp_dest(ramp_dest), .ramp_word(ramp_word),
        .par_en(par_en), .par_dest(par_d), .par_ftw(par_ftw),
        .ctl_ftw(ctl_ftw), .prof_ftw(prof_ftw),
        .word(ftw_d), .src(ftw_s)
    );

    dds_pa_sel #(.FTW_W(FTW_W), .POW_W(POW_W), .ASF_W(ASF_W), .PAR_W(PAR_W)) u_pa (
        .ram_en(ram_en), .ram_dest(ram_d), .ram_word(ram_word),
        .ramp_en(ramp_en), .ramp_dest(ramp_dest), .ramp_word(ramp_word),
        .par_en(par_en), .par_dest(par_d), .par_data(par_data),
        .par_pow_lsb(par_pow_lsb), .par_asf_lsb(par_asf_lsb),
        .osk_en(osk_en), .osk_amp(osk_amp),
        .ctl_pow(ctl_pow), .prof_pow(prof_pow), .prof_asf(prof_asf),
        .pow_word(pow_d), .pow_src(pow_s), .asf_word(asf_d), .asf_src(asf_s)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ftw_q  <= '0;
            pow_q  <= '0;
            asf_q  <= '0;
            ftw_sq <= SRC_PROFILE;
            pow_sq <= SRC_PROFILE;
            asf_sq <= SRC_PROFILE;
        end else begin
            ftw_q  <= ftw_d;
            pow_q  <= pow_d;
            asf_q  <= asf_d;
            ftw_sq <= ftw_s;
            pow_sq <= pow_s;
            asf_sq <= asf_s;
        end
    end

    assign ftw_src = ftw_sq;
    assign pow_src = pow_sq;
    assign asf_src = asf_sq;

    // R3
    ram_freq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_en && ram_dest == 2'd0) |=> (ftw_src == 3'd5 && ftw_q == $past(ram_word)));

    // R5
    osk_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        osk_en |=> (asf_src == 3'd6 && asf_q == $past(osk_amp)));

    // R8
    ram_polar_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_en && ram_dest == 2'd3 && !osk_en) |=>
        (pow_q == $past(ram_word[31:16]) && asf_q == $past(ram_word[15:2])));

    // R9
    ramp_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_en && ramp_dest == 2'd3 && !ram_en && !par_en && !osk_en) |=>
        (ftw_src == 3'd0 && pow_src == 3'd0 && asf_src == 3'd0));

    // R10
    src_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ftw_src != 3'd3 && ftw_src != 3'd6 && ftw_src != 3'd7 &&
         pow_src != 3'd6 && pow_src != 3'd7 && asf_src != 3'd1 && asf_src != 3'd7));
endmodule

// File: tb/dds_src_sel_bench.sv
module dds_src_sel_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ram_en, ramp_en, par_en, osk_en;
    logic [1:0]  ram_dest, ramp_dest, par_dest;
    logic [31:0] ram_word, ramp_word, par_base_ftw, ctl_ftw, prof_ftw;
    logic [3:0]  par_gain;
    logic [15:0] par_data, ctl_pow, prof_pow;
    logic [7:0]  par_pow_lsb;
    logic [5:0]  par_asf_lsb;
    logic [13:0] osk_amp, prof_asf;
    logic [31:0] ftw_q;
    logic [15:0] pow_q;
    logic [13:0] asf_q;
    logic [2:0]  ftw_src, pow_src, asf_src;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dds_src_sel u_dds_src_sel (
        .clk(clk), .rst_n(rst_n),
        .ram_en(ram_en), .ram_dest(ram_dest), .ram_word(ram_word),
        .ramp_en(ramp_en), .ramp_dest(ramp_dest), .ramp_word(ramp_word),
        .par_en(par_en), .par_dest(par_dest), .par_gain(par_gain),
        .par_data(par_data), .par_base_ftw(par_base_ftw),
        .par_pow_lsb(par_pow_lsb), .par_asf_lsb(par_asf_lsb),
        .osk_en(osk_en), .osk_amp(osk_amp),
        .ctl_ftw(ctl_ftw), .ctl_pow(ctl_pow),
        .prof_ftw(prof_ftw), .prof_pow(prof_pow), .prof_asf(prof_asf),
        .ftw_q(ftw_q), .pow_q(pow_q), .asf_q(asf_q),
        .ftw_src(ftw_src), .pow_src(pow_src), .asf_src(asf_src)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic defaults();
        ram_en = 0; ramp_en = 0; par_en = 0; osk_en = 0;
        ram_dest = 0; ramp_dest = 0; par_dest = 0;
        ram_word = 32'hABCD_1234; ramp_word = 32'h7654_3210;
        par_data = 16'h9A5C; par_gain = 4'd2; par_base_ftw = 32'h0100_0000;
        par_pow_lsb = 8'hC3; par_asf_lsb = 6'h2D; osk_amp = 14'h1F0F;
        ctl_ftw = 32'h4444_4444; ctl_pow = 16'h5555;
        prof_ftw = 32'h1111_1111; prof_pow = 16'h2222; prof_asf = 14'h0333;
    endtask

    // apply stimulus at a falling edge, check at the next falling edge
    task automatic step();
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "ftw", ftw_q, 0);
        chk("R1", "pow", {16'h0, pow_q}, 0);
        chk("R1", "asf", {18'h0, asf_q}, 0);
        chk("R1", "srcs", {23'h0, ftw_src, pow_src, asf_src}, 0);
    endtask

    task automatic t_profile();
        defaults(); step();
        chk("R10", "ftw profile", ftw_q, 32'h1111_1111);
        chk("R10", "pow profile", {16'h0, pow_q}, 32'h2222);
        chk("R10", "asf profile", {18'h0, asf_q}, 32'h0333);
        chk("R10", "src profile", {23'h0, ftw_src, pow_src, asf_src}, 0);
        prof_ftw = 32'h0BAD_F00D;
        #1 chk("R2", "ftw before edge", ftw_q, 32'h1111_1111);
        step();
        chk("R2", "ftw after edge", ftw_q, 32'h0BAD_F00D);
    endtask

    task automatic t_freq();
        defaults();
        ram_en = 1; ram_dest = 2'd0; ramp_en = 1; ramp_dest = 2'd0;
        par_en = 1; par_dest = 2'd0; step();
        chk("R3", "ram wins", ftw_q, 32'hABCD_1234);
        chk("R10", "ram code", {29'h0, ftw_src}, 5);
        ram_en = 0; step();
        chk("R3", "ramp wins", ftw_q, 32'h7654_3210);
        chk("R10", "ramp code", {29'h0, ftw_src}, 4);
        ramp_en = 0; step();
        chk("R3", "parallel wins", ftw_q, 32'h0102_6970);
        chk("R10", "parallel code", {29'h0, ftw_src}, 2);
        par_en = 0; ram_en = 1; ram_dest = 2'd2; step();
        chk("R3", "ctl ftw", ftw_q, 32'h4444_4444);
        chk("R10", "ctl code", {29'h0, ftw_src}, 1);
        chk("R8", "ram amp slice", {18'h0, asf_q}, 32'h2AF3);
        chk("R4", "ctl pow", {16'h0, pow_q}, 32'h5555);
    endtask

    task automatic t_par_scale();
        defaults(); par_en = 1; par_dest = 2'd0;
        par_base_ftw = 32'hFFFF_FF00; par_data = 16'h0100; par_gain = 0; step();
        chk("R6", "wrap", ftw_q, 32'h0000_0000);
        par_base_ftw = 32'h0000_0010; par_data = 16'hFFFF; par_gain = 4'd15; step();
        chk("R6", "max shift", ftw_q, 32'h7FFF_8010);
        par_base_ftw = 32'h1000_0000; par_data = 16'h1234; par_gain = 4'd4; step();
        chk("R6", "mid shift", ftw_q, 32'h1001_2340);
    endtask

    task automatic t_phase();
        defaults();
        ram_en = 1; ram_dest = 2'd3; ramp_en = 1; ramp_dest = 2'd1;
        par_en = 1; par_dest = 2'd1; step();
        chk("R4", "ram polar phase", {16'h0, pow_q}, 32'hABCD);
        chk("R8", "ram polar amp", {18'h0, asf_q}, 32'h048D);
        chk("R3", "ctl ftw under polar", ftw_q, 32'h4444_4444);
        ram_en = 0; step();
        chk("R9", "ramp phase", {16'h0, pow_q}, 32'h7654);
        ramp_en = 0; step();
        chk("R7", "parallel phase direct", {16'h0, pow_q}, 32'h9A5C);
        chk("R10", "parallel phase code", {29'h0, pow_src}, 2);
        par_dest = 2'd3; ram_en = 1; ram_dest = 2'd0; step();
        chk("R7", "polar phase", {16'h0, pow_q}, 32'h9AC3);
        chk("R7", "polar amp", {18'h0, asf_q}, 32'h172D);
        chk("R10", "polar code", {26'h0, pow_src, asf_src}, 6'o33);
        par_en = 0; step();
        chk("R4", "ctl pow", {16'h0, pow_q}, 32'h5555);
        chk("R3", "ram freq", ftw_q, 32'hABCD_1234);
    endtask

    task automatic t_amp();
        defaults();
        osk_en = 1; ram_en = 1; ram_dest = 2'd2; step();
        chk("R5", "osk wins", {18'h0, asf_q}, 32'h1F0F);
        chk("R10", "osk code", {29'h0, asf_src}, 6);
        osk_en = 0; step();
        chk("R5", "ram amp", {18'h0, asf_q}, 32'h2AF3);
        ram_en = 0; ramp_en = 1; ramp_dest = 2'd2; par_en = 1; par_dest = 2'd2; step();
        chk("R9", "ramp amp", {18'h0, asf_q}, 32'h1D95);
        ramp_en = 0; step();
        chk("R7", "parallel amp direct", {18'h0, asf_q}, 32'h2697);
        par_en = 0; step();
        chk("R5", "profile amp", {18'h0, asf_q}, 32'h0333);
    endtask

    task automatic t_ramp_none();
        defaults(); ramp_en = 1; ramp_dest = 2'd3; step();
        chk("R9", "ignored ftw", ftw_q, 32'h1111_1111);
        chk("R9", "ignored pow", {16'h0, pow_q}, 32'h2222);
        chk("R9", "ignored asf", {18'h0, asf_q}, 32'h0333);
        chk("R9", "ignored codes", {23'h0, ftw_src, pow_src, asf_src}, 0);
    endtask

    initial begin
        defaults();
        ram_en = 1; osk_en = 1; par_en = 1;
        rst_n = 0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        t_profile();
        t_freq();
        t_par_scale();
        t_phase();
        t_amp();
        t_ramp_none();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule